// File: doc/BRIEF.md
# Double-Buffered Column Code and Drive Mode Executor

This block carries out decoded serial commands for a passive matrix driver with 128 columns and 128 rows. Each column has a 7-bit drive code, where one count is one unit of column current. The block keeps two complete banks of these codes. The host writes one bank, called the shadow bank, while the other bank, called the visible bank, feeds the column outputs. A dedicated swap command exchanges the two roles on one clock edge, so the outputs never show a frame that is only partly written.

The block also holds the selected row index and two small mode registers, one for the row drivers and one for the column drivers. Row-address writes and a family of soft commands update these registers. All soft commands share one command code and are told apart by the data byte.

The block's input is a one-cycle strobe from the serial front end. The strobe carries a 4-bit command code, an 8-bit address and an 8-bit data byte. Every register that the strobe changes takes its new value on the same rising edge that samples the strobe.

Top module: `pcx_exec`

## Requirements
- R1: After reset, `bank_sel` is 0, every column code in both banks is 0, `row_sel` is 0, `row_mode` is 0 (rows off) and `col_mode` is 0 (columns off).
- R2: A strobe with code 8 changes no output and no stored state.
- R3: A strobe with code 1 inverts `bank_sel`. From the next cycle, `col_codes` presents the bank that was the shadow bank.
- R4: A strobe with code 4 and an address below NUM_COLS stores data bits 6:0 into that column of the shadow bank, and data bit 7 is ignored. `col_codes` shows no change until a code 1 strobe. Column c occupies bits c*7+6 down to c*7.
- R5: A code 4 strobe whose address is NUM_COLS or more changes neither bank.
- R6: A strobe with code 2 and an address below NUM_ROWS loads `row_sel` with that address and sets `row_mode` to 1 (row drive).
- R7: A code 2 strobe whose address is NUM_ROWS or more leaves `row_sel` and `row_mode` unchanged.
- R8: Code 3 controls the column mode through its data byte. Data 0x2C sets `col_mode` to 1 (drive), 0x21 sets it to 2 (forced low) and 0x22 sets it to 3 (forced high). `row_mode` is unchanged.
- R9: Code 3 with data 0x20 sets both `row_mode` and `col_mode` to 0. Code 3 with data 0x28 sets `row_mode` to 2 (rows forced low) and leaves `col_mode` unchanged.
- R10: A code 3 strobe with any other data byte changes nothing.
- R11: Codes 0, 5, 6, 7 and 9 to 15 change nothing, and neither does any input while `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 4 | Command code |
| cmd_addr | input | 8 | Column or row address |
| cmd_data | input | 8 | Column code or soft-command selector |
| col_codes | output | NUM_COLS*7 | Visible-bank codes; column c at bits c*7+6:c*7 |
| bank_sel | output | 1 | Index of the visible bank |
| row_sel | output | $clog2(NUM_ROWS) | Selected row index |
| row_mode | output | 2 | 0 off, 1 drive, 2 forced low |
| col_mode | output | 2 | 0 off, 1 drive, 2 forced low, 3 forced high |

## Verification
A column write that lands in the visible bank instead of the shadow bank shows at once: that column of `col_codes` moves on the cycle after the strobe, with no swap. A write that lands in the wrong shadow cell, or is lost, stays hidden until the next swap, when the affected column shows a code that differs from the expected one. Any wrong decode of a mode or row command appears on the mode and row outputs one cycle after its strobe. The bench therefore compares every output after every command. It also swaps banks after each group of writes, so that shadow contents become visible at the ports.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

  localparam int unsigned CODE_W = 7;

  localparam logic [3:0] OP_NOP    = 4'h8;
  localparam logic [3:0] OP_SWAP   = 4'h1;
  localparam logic [3:0] OP_ROW    = 4'h2;
  localparam logic [3:0] OP_SOFT   = 4'h3;
  localparam logic [3:0] OP_COLWR  = 4'h4;

  localparam logic [7:0] SOFT_ALL_OFF = 8'h20;
  localparam logic [7:0] SOFT_COL_LO  = 8'h21;
  localparam logic [7:0] SOFT_COL_HI  = 8'h22;
  localparam logic [7:0] SOFT_ROW_LO  = 8'h28;
  localparam logic [7:0] SOFT_COL_ON  = 8'h2C;

  typedef enum logic [1:0] {
    COL_OFF      = 2'd0,
    COL_DRIVE    = 2'd1,
    COL_FORCE_LO = 2'd2,
    COL_FORCE_HI = 2'd3
  } col_mode_e;

  typedef enum logic [1:0] {
    ROW_OFF      = 2'd0,
    ROW_DRIVE    = 2'd1,
    ROW_FORCE_LO = 2'd2
  } row_mode_e;

  typedef struct packed {
    logic      hit;
    logic      col_upd;
    col_mode_e col_val;
    logic      row_upd;
    row_mode_e row_val;
  } soft_act_t;

  // True when an 8-bit address selects an existing column or row.
  function automatic logic in_range(input logic [7:0] a, input int unsigned lim);
    return 32'(a) < lim;
  endfunction

  // Maps a soft-command selector byte onto the mode updates it requests.
  function automatic soft_act_t soft_lookup(input logic [7:0] sel);
    soft_act_t act;
    act = '{hit: 1'b0, col_upd: 1'b0, col_val: COL_OFF,
            row_upd: 1'b0, row_val: ROW_OFF};
    case (sel)
      SOFT_ALL_OFF: begin
        act.hit = 1'b1; act.col_upd = 1'b1; act.col_val = COL_OFF;
        act.row_upd = 1'b1; act.row_val = ROW_OFF;
      end
      SOFT_COL_LO: begin
        act.hit = 1'b1; act.col_upd = 1'b1; act.col_val = COL_FORCE_LO;
      end
      SOFT_COL_HI: begin
        act.hit = 1'b1; act.col_upd = 1'b1; act.col_val = COL_FORCE_HI;
      end
      SOFT_ROW_LO: begin
        act.hit = 1'b1; act.row_upd = 1'b1; act.row_val = ROW_FORCE_LO;
      end
      SOFT_COL_ON: begin
        act.hit = 1'b1; act.col_upd = 1'b1; act.col_val = COL_DRIVE;
      end
      default: ;
    endcase
    return act;
  endfunction

endpackage

// File: rtl/pcx_decode.sv
module pcx_decode
  import pcx_pkg::*;
#(
  parameter int unsigned NUM_COLS = 128,
  parameter int unsigned NUM_ROWS = 128,
  localparam int unsigned COL_W = $clog2(NUM_COLS),
  localparam int unsigned ROW_W = $clog2(NUM_ROWS)
) (
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_code,
  input  logic [7:0]       cmd_addr,
  input  logic [7:0]       cmd_data,
  output logic             ev_swap,
  output logic             ev_col_wr,
  output logic [COL_W-1:0] wr_col,
  output logic [CODE_W-1:0] wr_code,
  output logic             ev_row_wr,
  output logic [ROW_W-1:0] wr_row,
  output soft_act_t        soft_act
);

  soft_act_t lookup;

  always_comb begin
    lookup    = soft_lookup(cmd_data);
    ev_swap   = cmd_valid && (cmd_code == OP_SWAP);
    ev_col_wr = cmd_valid && (cmd_code == OP_COLWR) && in_range(cmd_addr, NUM_COLS);
    ev_row_wr = cmd_valid && (cmd_code == OP_ROW) && in_range(cmd_addr, NUM_ROWS);
    wr_col    = cmd_addr[COL_W-1:0];
    wr_row    = cmd_addr[ROW_W-1:0];
    wr_code   = cmd_data[CODE_W-1:0];
    soft_act  = lookup;
    if (!(cmd_valid && (cmd_code == OP_SOFT))) begin
      soft_act.hit     = 1'b0;
      soft_act.col_upd = 1'b0;
      soft_act.row_upd = 1'b0;
    end
  end

endmodule

// File: rtl/pcx_col_banks.sv
module pcx_col_banks
  import pcx_pkg::*;
#(
  parameter int unsigned NUM_COLS = 128,
  localparam int unsigned COL_W = $clog2(NUM_COLS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       swap,
  input  logic                       wr_en,
  input  logic [COL_W-1:0]           wr_col,
  input  logic [CODE_W-1:0]          wr_code,
  output logic [NUM_COLS*CODE_W-1:0] col_codes,
  output logic                       bank_sel
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank_sel <= 1'b0;
    else if (swap) bank_sel <= ~bank_sel;
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [CODE_W-1:0] cell0;
    logic [CODE_W-1:0] cell1;
    logic              hit;

    assign hit = wr_en && (wr_col == COL_W'(c));

    // Shadow bank is the one not selected for output.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell0 <= '0;
        cell1 <= '0;
      end else if (hit) begin
        if (bank_sel) cell0 <= wr_code;
        else          cell1 <= wr_code;
      end
    end

    assign col_codes[c*CODE_W +: CODE_W] = bank_sel ? cell1 : cell0;
  end

endmodule

// File: rtl/pcx_ctrl_regs.sv
module pcx_ctrl_regs
  import pcx_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 128,
  localparam int unsigned ROW_W = $clog2(NUM_ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_wr,
  input  logic [ROW_W-1:0] row_addr,
  input  soft_act_t        soft_act,
  output logic [ROW_W-1:0] row_sel,
  output row_mode_e        row_mode,
  output col_mode_e        col_mode
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_sel  <= '0;
      row_mode <= ROW_OFF;
      col_mode <= COL_OFF;
    end else if (row_wr) begin
      row_sel  <= row_addr;
      row_mode <= ROW_DRIVE;
    end else if (soft_act.hit) begin
      if (soft_act.col_upd) col_mode <= soft_act.col_val;
      if (soft_act.row_upd) row_mode <= soft_act.row_val;
    end
  end

endmodule

// File: rtl/pcx_exec.sv
module pcx_exec
  import pcx_pkg::*;
#(
  parameter int unsigned NUM_COLS = 128,
  parameter int unsigned NUM_ROWS = 128,
  localparam int unsigned COL_W = $clog2(NUM_COLS),
  localparam int unsigned ROW_W = $clog2(NUM_ROWS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [3:0]                 cmd_code,
  input  logic [7:0]                 cmd_addr,
  input  logic [7:0]                 cmd_data,
  output logic [NUM_COLS*CODE_W-1:0] col_codes,
  output logic                       bank_sel,
  output logic [ROW_W-1:0]           row_sel,
  output logic [1:0]                 row_mode,
  output logic [1:0]                 col_mode
);

  // Named internal events, visible to the bound checker.
  logic              ev_swap;
  logic              ev_col_wr;
  logic              ev_row_wr;
  logic [COL_W-1:0]  wr_col;
  logic [ROW_W-1:0]  wr_row;
  logic [CODE_W-1:0] wr_code;
  soft_act_t         soft_act;
  row_mode_e         row_mode_q;
  col_mode_e         col_mode_q;

  pcx_decode #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_decode (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .ev_swap   (ev_swap),
    .ev_col_wr (ev_col_wr),
    .wr_col    (wr_col),
    .wr_code   (wr_code),
    .ev_row_wr (ev_row_wr),
    .wr_row    (wr_row),
    .soft_act  (soft_act)
  );

  pcx_col_banks #(.NUM_COLS(NUM_COLS)) u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .swap      (ev_swap),
    .wr_en     (ev_col_wr),
    .wr_col    (wr_col),
    .wr_code   (wr_code),
    .col_codes (col_codes),
    .bank_sel  (bank_sel)
  );

  pcx_ctrl_regs #(.NUM_ROWS(NUM_ROWS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_wr   (ev_row_wr),
    .row_addr (wr_row),
    .soft_act (soft_act),
    .row_sel  (row_sel),
    .row_mode (row_mode_q),
    .col_mode (col_mode_q)
  );

  assign row_mode = row_mode_q;
  assign col_mode = col_mode_q;

endmodule

// File: rtl/pcx_exec_chk.sv
module pcx_exec_chk
  import pcx_pkg::*;
#(
  parameter int unsigned NUM_COLS = 128,
  parameter int unsigned NUM_ROWS = 128,
  localparam int unsigned ROW_W = $clog2(NUM_ROWS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_valid,
  input logic [3:0]                 cmd_code,
  input logic [7:0]                 cmd_addr,
  input logic [7:0]                 cmd_data,
  input logic [NUM_COLS*CODE_W-1:0] col_codes,
  input logic                       bank_sel,
  input logic [ROW_W-1:0]           row_sel,
  input logic [1:0]                 row_mode,
  input logic [1:0]                 col_mode,
  input logic                       ev_swap,
  input logic                       ev_col_wr,
  input logic                       ev_row_wr,
  input logic                       soft_hit
);

  assert_swap_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_swap |=> bank_sel != $past(bank_sel));

  assert_visible_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_swap |=> $stable(col_codes) && $stable(bank_sel));

  assert_nop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == OP_NOP) |=>
      $stable(row_sel) && $stable(row_mode) && $stable(col_mode) && $stable(bank_sel));

  assert_row_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_row_wr |=> (row_sel == $past(cmd_addr[ROW_W-1:0])) && (row_mode == 2'd1));

  assert_row_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == OP_ROW && 32'(cmd_addr) >= NUM_ROWS) |=>
      $stable(row_sel) && $stable(row_mode));

  assert_force_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == OP_SOFT && cmd_data == SOFT_COL_HI) |=> col_mode == 2'd3);

  assert_all_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == OP_SOFT && cmd_data == SOFT_ALL_OFF) |=>
      (col_mode == 2'd0) && (row_mode == 2'd0));

  assert_one_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_swap, ev_col_wr, ev_row_wr, soft_hit}));

  assert_row_mode_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    row_mode != 2'd3);

endmodule

bind pcx_exec pcx_exec_chk #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .cmd_addr  (cmd_addr),
  .cmd_data  (cmd_data),
  .col_codes (col_codes),
  .bank_sel  (bank_sel),
  .row_sel   (row_sel),
  .row_mode  (row_mode),
  .col_mode  (col_mode),
  .ev_swap   (ev_swap),
  .ev_col_wr (ev_col_wr),
  .ev_row_wr (ev_row_wr),
  .soft_hit  (soft_act.hit)
);

// File: tb/pcx_exec_bench.sv
`timescale 1ns/1ps
module pcx_exec_bench;

  localparam int NC = 8;
  localparam int NR = 8;
  localparam int CW = 7;
  localparam int RW = $clog2(NR);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_valid = 1'b0;
  logic [3:0]      cmd_code = '0;
  logic [7:0]      cmd_addr = '0;
  logic [7:0]      cmd_data = '0;
  logic [NC*CW-1:0] col_codes;
  logic            bank_sel;
  logic [RW-1:0]   row_sel;
  logic [1:0]      row_mode;
  logic [1:0]      col_mode;

  int checks = 0;
  int errors = 0;

  // Bench-side model built from the requirements.
  logic [6:0] m_bank [2][NC];
  int         m_sel, m_row, m_rmode, m_cmode;

  always #4 clk = ~clk;

  pcx_exec #(.NUM_COLS(NC), .NUM_ROWS(NR)) u_pcx_exec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .col_codes(col_codes),
    .bank_sel(bank_sel), .row_sel(row_sel), .row_mode(row_mode), .col_mode(col_mode)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(req, "bank_sel", int'(bank_sel), m_sel);
    chk(req, "row_sel", int'(row_sel), m_row);
    chk(req, "row_mode", int'(row_mode), m_rmode);
    chk(req, "col_mode", int'(col_mode), m_cmode);
    for (int c = 0; c < NC; c++)
      chk(req, $sformatf("col%0d", c), int'(col_codes[c*CW +: CW]), int'(m_bank[m_sel][c]));
  endtask

  // Expected effect of one strobe, taken from R2..R11.
  task automatic model(input int code, input int addr, input int data);
    case (code)
      1: m_sel = 1 - m_sel;
      2: if (addr < NR) begin m_row = addr; m_rmode = 1; end
      4: if (addr < NC) m_bank[1 - m_sel][addr] = 7'(data % 128);
      3: case (data)
           'h20: begin m_cmode = 0; m_rmode = 0; end
           'h21: m_cmode = 2;
           'h22: m_cmode = 3;
           'h28: m_rmode = 2;
           'h2C: m_cmode = 1;
           default: ;
         endcase
      default: ;
    endcase
  endtask

  task automatic apply(input int code, input int addr, input int data, input string req);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = 4'(code);
    cmd_addr  = 8'(addr);
    cmd_data  = 8'(data);
    @(negedge clk);
    cmd_valid = 1'b0;
    model(code, addr, data);
    check_state(req);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < NC; c++) m_bank[b][c] = '0;
    m_sel = 0; m_row = 0; m_rmode = 0; m_cmode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");

    // R2: no-operation with assorted fields
    for (int i = 0; i < 16; i++) apply(8, i * 17, 255 - i * 13, "R2");

    // R4 then R3: fill shadow bank, including data with bit 7 set
    for (int c = 0; c < NC; c++) apply(4, c, (c * 37 + 200) % 256, "R4");
    apply(1, 0, 0, "R3");
    for (int c = 0; c < NC; c++) apply(4, c, (c * 53 + 9) % 256, "R4");
    apply(1, 0, 0, "R3");

    // R5: out-of-range column writes, then expose the shadow bank
    for (int a = NC; a < 256; a++) apply(4, a, a, "R5");
    apply(1, 0, 0, "R5");
    apply(1, 0, 0, "R5");

    // R6 / R7: every row address
    for (int a = 0; a < 256; a++) apply(2, a, 0, (a < NR) ? "R6" : "R7");

    // R8 / R9 / R10: every soft selector from two different prior states
    for (int d = 0; d < 256; d++) begin
      string tag;
      if (d == 'h21 || d == 'h22 || d == 'h2C) tag = "R8";
      else if (d == 'h20 || d == 'h28)         tag = "R9";
      else                                     tag = "R10";
      if (d % 2 == 0) begin
        apply(3, 0, 'h22, "R8");
        apply(2, 5, 0, "R6");
      end else begin
        apply(3, 0, 'h2C, "R8");
        apply(3, 0, 'h28, "R9");
      end
      apply(3, d % 7, d, tag);
    end

    // R11: unassigned codes, with a column write pending in the shadow
    for (int code = 0; code < 16; code++) begin
      if (code == 1 || code == 2 || code == 3 || code == 4 || code == 8) continue;
      apply(code, 3, 'h22, "R11");
      apply(code, 2, 'h20, "R11");
    end
    apply(1, 0, 0, "R11");
    // R11: strobe low, fields that would otherwise swap, write and clear
    @(negedge clk);
    cmd_code = 4'h1; cmd_addr = 8'h02; cmd_data = 8'h20;
    @(negedge clk);
    cmd_code = 4'h4;
    @(negedge clk);
    cmd_code = 4'h3;
    @(negedge clk);
    check_state("R11");
    apply(1, 0, 0, "R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule